// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire slave that gives a host read and write access to a small bank of 8-bit configuration registers. SCL and SDA are sampled with a fast system clock. The block detects START, repeated START and STOP conditions and compares the first byte of each transfer against a fixed 7-bit address. It pulls SDA low through an open-drain enable, both to acknowledge and to send read data.

The byte after the address byte is a command code. When its top bit is set, the code's low seven bits pick one register, and a transfer may then move one byte or two consecutive bytes. When its top bit is clear, the transfer is a block transfer. A block write carries a count byte, and a block read returns a count byte before the data. A block transfer always starts at register 0 and walks upward. All register contents are driven in parallel on a flat output bus, which feeds the logic that uses the settings.

Top module: `smb_cfg_slave`

## Requirements
- R1: The first byte after a START holds a 7-bit address followed by a direction bit, where 0 means write and 1 means read. The slave pulls SDA low in the ninth clock only if the address equals SLV_ADDR. After any other address, SDA stays released for all later clocks until the next START.
- R2: Command code bit 7 = 1 selects indexed access to the register numbered by bits 6:0. Bit 7 = 0 selects block access, which starts at register 0.
- R3: An indexed write of one data byte updates only the addressed register. An indexed read, made through a repeated START and the read address, returns that register's value.
- R4: A two-byte indexed write stores the first data byte at the offset and the second byte at offset+1. A two-byte read returns them in the same order, first the offset and then offset+1.
- R5: In a block write, the first byte after the command is a count. The slave acknowledges it and does not store it. The data bytes that follow go to registers 0, 1, 2 and so on. Every byte is acknowledged, and bytes past register NREG-1 are dropped.
- R6: A block read first returns the byte NREG, then registers 0, 1, 2 and so on. A host NACK ends the transmission: SDA stays released until the next START or STOP.
- R7: A write to an offset at or above NREG is acknowledged and changes no register. A read from such an offset returns 0x00.
- R8: A STOP at any point returns the slave to idle. Bytes already completed stay written, and a partly shifted byte is never written. The next transfer then works normally.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: After reset, every register reads 0x00 and SDA is released.
- R11: Register k appears on regs_o[8k+7:8k]. The bus changes only when a register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREG*8 | All registers, register k in bits [8k+7:8k] |

## Verification
The bench builds the slave with SLV_ADDR = 7'h2C, NREG = 8 and two synchronizer stages. With eight registers, a two-byte access at offset 7 straddles the end of the bank. An eleven-byte block write overruns it, and a full block read (count byte plus eight data bytes) stays short. The neighbouring address 7'h2D is used to exercise the silent path after an address mismatch. A STOP is also issued inside a partly shifted data byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int OFS_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } smb_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int NREG  = 8,
  parameter int IDX_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [7:0]         rd_data,
  output logic [NREG*8-1:0]  regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] val_q;
    logic       hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= wr_data;
      end
    end

    assign regs_flat[g*8 +: 8] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = regs_flat[k*8 +: 8];
    end
  end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h2C,
  parameter int         NREG        = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);

  localparam logic [7:0]       CNT_BYTE = 8'(NREG);
  localparam logic [OFS_W-1:0] PTR_MAX  = '1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_state_t       state_q, state_n;
  logic [3:0]       bitcnt_q, bitcnt_n;
  logic             ack_ph_q, ack_ph_n;
  logic             ack_drv_q, ack_drv_n;
  logic             nack_q, nack_n;
  logic [7:0]       rx_q, rx_n;
  logic [7:0]       tx_q, tx_n;
  logic             blk_q, blk_n;
  logic             cnt_pend_q, cnt_pend_n;
  logic             rd_cnt_q, rd_cnt_n;
  logic [OFS_W-1:0] ptr_q, ptr_n, ptr_inc;

  logic             wr_en;
  logic [OFS_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;

  smb_reg_bank #(.NREG(NREG), .IDX_W(OFS_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (ptr_q),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

  assign ptr_inc = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;

  // Next-state process
  always_comb begin
    state_n    = state_q;
    bitcnt_n   = bitcnt_q;
    ack_ph_n   = ack_ph_q;
    ack_drv_n  = ack_drv_q;
    nack_n     = nack_q;
    rx_n       = rx_q;
    tx_n       = tx_q;
    blk_n      = blk_q;
    cnt_pend_n = cnt_pend_q;
    rd_cnt_n   = rd_cnt_q;
    ptr_n      = ptr_q;
    wr_en      = 1'b0;
    wr_idx     = ptr_q;
    wr_data    = rx_q;

    if (stop_det) begin
      state_n   = ST_IDLE;
      ack_ph_n  = 1'b0;
      ack_drv_n = 1'b0;
    end else if (start_det) begin
      state_n   = ST_ADDR;
      bitcnt_n  = '0;
      ack_ph_n  = 1'b0;
      ack_drv_n = 1'b0;
    end else if (state_q != ST_IDLE && state_q != ST_SKIP) begin
      if (!ack_ph_q) begin
        if (scl_rise) begin
          bitcnt_n = bitcnt_q + 1'b1;
          rx_n     = {rx_q[6:0], sda_s};
        end else if (scl_fall) begin
          if (bitcnt_q == 4'd8) begin
            ack_ph_n = 1'b1;
            bitcnt_n = '0;
            unique case (state_q)
              ST_ADDR: begin
                if (rx_q[7:1] == SLV_ADDR) begin
                  ack_drv_n = 1'b1;
                  if (rx_q[0]) begin
                    state_n  = ST_RDATA;
                    rd_cnt_n = blk_q;
                  end else begin
                    state_n  = ST_CMD;
                  end
                end else begin
                  state_n  = ST_SKIP;
                  ack_ph_n = 1'b0;
                end
              end
              ST_CMD: begin
                ack_drv_n = 1'b1;
                state_n   = ST_WDATA;
                if (rx_q[7]) begin
                  blk_n      = 1'b0;
                  ptr_n      = rx_q[6:0];
                  cnt_pend_n = 1'b0;
                end else begin
                  blk_n      = 1'b1;
                  ptr_n      = '0;
                  cnt_pend_n = 1'b1;
                end
              end
              ST_WDATA: begin
                ack_drv_n = 1'b1;
                if (cnt_pend_q) begin
                  cnt_pend_n = 1'b0;
                end else begin
                  wr_en = (int'(ptr_q) < NREG);
                  ptr_n = ptr_inc;
                end
              end
              ST_RDATA: begin
                ack_drv_n = 1'b0;
                nack_n    = 1'b0;
              end
              default: begin
                state_n  = ST_IDLE;
                ack_ph_n = 1'b0;
              end
            endcase
          end else if (state_q == ST_RDATA && bitcnt_q != 4'd0) begin
            tx_n = {tx_q[6:0], 1'b1};
          end
        end
      end else begin
        if (scl_rise && !ack_drv_q) begin
          nack_n = sda_s;
        end else if (scl_fall) begin
          ack_ph_n  = 1'b0;
          ack_drv_n = 1'b0;
          bitcnt_n  = '0;
          if (state_q == ST_RDATA) begin
            if (!ack_drv_q && nack_q) begin
              state_n = ST_SKIP;
            end else if (rd_cnt_q) begin
              tx_n     = CNT_BYTE;
              rd_cnt_n = 1'b0;
            end else begin
              tx_n  = rd_data;
              ptr_n = ptr_inc;
            end
          end
        end
      end
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      ack_ph_q   <= 1'b0;
      ack_drv_q  <= 1'b0;
      nack_q     <= 1'b0;
      rx_q       <= '0;
      tx_q       <= '1;
      blk_q      <= 1'b0;
      cnt_pend_q <= 1'b0;
      rd_cnt_q   <= 1'b0;
      ptr_q      <= '0;
    end else begin
      state_q    <= state_n;
      bitcnt_q   <= bitcnt_n;
      ack_ph_q   <= ack_ph_n;
      ack_drv_q  <= ack_drv_n;
      nack_q     <= nack_n;
      rx_q       <= rx_n;
      tx_q       <= tx_n;
      blk_q      <= blk_n;
      cnt_pend_q <= cnt_pend_n;
      rd_cnt_q   <= rd_cnt_n;
      ptr_q      <= ptr_n;
    end
  end

  assign sda_oe = (ack_ph_q & ack_drv_q) |
                  ((state_q == ST_RDATA) & ~ack_ph_q & ~tx_q[7]);

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              stop_det,
  input logic              wr_en,
  input logic [6:0]        wr_idx,
  input logic              in_skip,
  input logic [NREG*8-1:0] regs_o
);

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  a_r7_write_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));

  a_r1_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !sda_oe);

  a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .in_skip  (state_q == smb_cfg_pkg::ST_SKIP),
  .regs_o   (regs_o)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;

  localparam logic [6:0] ADDR = 7'h2C;
  localparam int         NR   = 8;
  localparam int         Q    = 10;

  typedef struct packed {
    logic [7:0] off;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] elo;
    logic [7:0] ehi;
  } vec_t;

  // Two-byte write at off, then two-byte read back (R4, R7)
  localparam vec_t VECS [5] = '{
    '{8'h00, 8'h11, 8'h22, 8'h11, 8'h22},
    '{8'h03, 8'hA5, 8'h5A, 8'hA5, 8'h5A},
    '{8'h06, 8'h01, 8'h02, 8'h01, 8'h02},
    '{8'h07, 8'h77, 8'h88, 8'h77, 8'h00},
    '{8'h09, 8'hFF, 8'hEE, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire  sda_bus = sda_h & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int oe_viol = 0;
  logic done = 1'b0;
  logic [7:0] mdl [NR];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  smb_cfg_slave #(.SLV_ADDR(ADDR), .NREG(NR), .SYNC_STAGES(2)) i_smb_cfg_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_h),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe),
    .regs_o (regs_o)
  );

  // R9 monitor: drive changes seen while SCL is high
  logic scl_prev = 1'b1;
  logic oe_prev  = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_h && scl_prev && (sda_oe != oe_prev)) oe_viol++;
    scl_prev <= scl_h;
    oe_prev  <= sda_oe;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] packed_mdl();
    logic [NR*8-1:0] v;
    for (int k = 0; k < NR; k++) v[k*8 +: 8] = mdl[k];
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_h = b;    tick(Q);
    scl_h = 1'b1; tick(Q);
    s = sda_bus;  tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic last);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(last, s);
  endtask

  task automatic do_write(input logic [7:0] cmd, input int n, input string req);
    logic a;
    int   miss = 0;
    bus_start();
    put_byte({ADDR, 1'b0}, a); if (!a) miss++;
    put_byte(cmd, a);          if (!a) miss++;
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a);
      if (!a) miss++;
    end
    bus_stop();
    tick(Q);
    check(req, 64'(miss), 64'd0);
  endtask

  task automatic do_read(input logic [7:0] cmd, input int n, input string req);
    logic a;
    logic [7:0] d;
    int   miss = 0;
    bus_start();
    put_byte({ADDR, 1'b0}, a); if (!a) miss++;
    put_byte(cmd, a);          if (!a) miss++;
    bus_start();
    put_byte({ADDR, 1'b1}, a); if (!a) miss++;
    for (int i = 0; i < n; i++) begin
      get_byte(d, (i == n - 1));
      rbuf[i] = d;
    end
    bus_stop();
    tick(Q);
    check(req, 64'(miss), 64'd0);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic a;
    logic s;
    for (int k = 0; k < NR; k++) mdl[k] = 8'h00;
    tick(5);
    // R10: reset state
    check("R10 regs after reset", 64'(regs_o), 64'd0);
    check("R10 sda after reset", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    tick(Q);

    // Table walk: two-byte accesses (R4, R7, R11)
    for (int v = 0; v < 5; v++) begin
      wbuf[0] = VECS[v].lo;
      wbuf[1] = VECS[v].hi;
      do_write({1'b1, VECS[v].off[6:0]}, 2, "R1 ack on word write");
      if (VECS[v].off < NR)     mdl[VECS[v].off]     = VECS[v].lo;
      if (VECS[v].off + 1 < NR) mdl[VECS[v].off + 1] = VECS[v].hi;
      check("R11 regs after word write", 64'(regs_o), 64'(packed_mdl()));
      do_read({1'b1, VECS[v].off[6:0]}, 2, "R1 ack on word read");
      check("R4 word read low", 64'(rbuf[0]), 64'(VECS[v].elo));
      check("R4 word read high", 64'(rbuf[1]), 64'(VECS[v].ehi));
    end

    // R3: single byte write and read
    wbuf[0] = 8'h3C;
    do_write(8'h82, 1, "R3 byte write ack");
    mdl[2] = 8'h3C;
    check("R3 byte write target", 64'(regs_o), 64'(packed_mdl()));
    do_read(8'h82, 1, "R3 byte read ack");
    check("R3 byte read data", 64'(rbuf[0]), 64'h3C);

    // R1: mismatching address is never acknowledged
    bus_start();
    put_byte({7'h2D, 1'b0}, a);
    check("R1 foreign address ack", 64'(a), 64'd0);
    put_byte(8'h81, a);
    check("R1 silent after mismatch", 64'(a), 64'd0);
    put_byte(8'h99, a);
    check("R1 silent data after mismatch", 64'(a), 64'd0);
    bus_stop();
    tick(Q);
    check("R1 regs untouched", 64'(regs_o), 64'(packed_mdl()));

    // R5, R2: block write of three bytes
    wbuf[0] = 8'd3; wbuf[1] = 8'hC0; wbuf[2] = 8'hC1; wbuf[3] = 8'hC2;
    do_write(8'h00, 4, "R5 block write acks");
    mdl[0] = 8'hC0; mdl[1] = 8'hC1; mdl[2] = 8'hC2;
    check("R2 block from reg0", 64'(regs_o), 64'(packed_mdl()));

    // R5: overlong block write, extra bytes dropped but acked
    wbuf[0] = 8'd11;
    for (int i = 0; i < 11; i++) wbuf[i + 1] = 8'hD0 + 8'(i);
    do_write(8'h00, 12, "R5 overlong block acks");
    for (int k = 0; k < NR; k++) mdl[k] = 8'hD0 + 8'(k);
    check("R5 overlong block contents", 64'(regs_o), 64'(packed_mdl()));

    // R6: block read returns count then registers
    do_read(8'h00, NR + 1, "R6 block read acks");
    check("R6 count byte", 64'(rbuf[0]), 64'(NR));
    for (int k = 0; k < NR; k++) check("R6 block read data", 64'(rbuf[k + 1]), 64'(mdl[k]));

    // R8: host stops a block write early
    wbuf[0] = 8'd8; wbuf[1] = 8'hE0; wbuf[2] = 8'hE1;
    do_write(8'h00, 3, "R8 early stop acks");
    mdl[0] = 8'hE0; mdl[1] = 8'hE1;
    check("R8 completed bytes kept", 64'(regs_o), 64'(packed_mdl()));

    // R8: STOP inside a partly shifted byte
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h85, a);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    bus_stop();
    tick(Q);
    check("R8 partial byte dropped", 64'(regs_o), 64'(packed_mdl()));
    do_read(8'h85, 1, "R8 recovery read ack");
    check("R8 recovery read data", 64'(rbuf[0]), 64'(mdl[5]));

    // R6: host NACKs after the count byte
    do_read(8'h00, 1, "R6 short block read ack");
    check("R6 short block count", 64'(rbuf[0]), 64'(NR));
    do_read(8'h80, 1, "R6 read after NACK ack");
    check("R6 read after NACK data", 64'(rbuf[0]), 64'(mdl[0]));

    // R7: far out-of-range offset
    wbuf[0] = 8'h5F;
    do_write(8'hF0, 1, "R7 out of range write ack");
    check("R7 out of range write ignored", 64'(regs_o), 64'(packed_mdl()));
    do_read(8'hF0, 1, "R7 out of range read ack");
    check("R7 out of range read zero", 64'(rbuf[0]), 64'h00);

    // R9: drive changes only with SCL low
    check("R9 sda changes while scl high", 64'(oe_viol), 64'd0);

    done = 1'b1;
    report();
    $finish;
  end

endmodule